// File: doc/BRIEF.md
# Statistical Cell Impairment Injector

This block sits in a byte-serial cell stream and damages selected cells at random spacings. Each cell is `CELL_LEN` bytes long. Its first byte is flagged by a start strobe, and an empty flag marks idle slots. The first `HDR_LEN` bytes form the header. A header selector compares the header against a programmable key under a mask, or it accepts every non-empty cell. Only cells that pass the selector take part in the interval count.

The spacing between impairment events is measured in matching cells. It is drawn from a loaded interval table. A 17-bit pseudorandom shift register picks an entry of that table, and the entry is counted down on matching cells. When the count runs out, the block fires an event. Three modes are available:

- Loss: the cell is turned into an empty cell. A burst of up to 8 consecutive matching cells can be lost.
- Bit error: 1 to 4 adjacent bits of one payload byte are flipped.
- Misinsertion: the next empty slot is replaced by a cell built from a programmable header and fill byte.

Burst lengths come from an 8-entry code table, indexed by a second shift register that uses a different polynomial. Cells leave the block `CELL_LEN + 1` cycles after they enter, in the same order.

Top module: `cell_impair_injector`

## Requirements
- R1: After reset, `outStart` is 0, `outEmpty` is 1 and `outData` is 0.
- R2: A cell that is not impaired leaves the block with identical bytes, start position and empty flag, in arrival order. This covers every cell while `enable` is 0.
- R3: A cell matches when it is non-empty and either `allCells` is 1 or `((header ^ chanKey) & chanMask) == 0`. The header byte 0 sits in bits [8*HDR_LEN-1 -: 8]. Empty cells never match. A non-empty cell that does not match is never impaired and does not advance the interval count.
- R4: The table is written through `tabWe`/`tabAddr`/`tabData` only while `enable` is 0. The interval count restarts each time `enable` rises. With every entry equal to K, loss mode (`mode` = 0) and burst code 0, the K-th, 2K-th, 3K-th … matching cells are lost.
- R5: A table entry of 0 acts as 1, so every matching cell starts an event.
- R6: A lost cell leaves the block with `outEmpty` = 1 and all data bytes 0.
- R7: The burst code c is taken from `burstTab[3*i +: 3]`, where i is pseudorandom. A loss event removes c+1 consecutive matching cells, starting with the cell that fires the event. The count is frozen during the burst, and the next event is the K-th matching cell after the burst.
- R8: In bit-error mode (`mode` = 1), each event corrupts one cell. Byte `ERR_BYTE` of that cell (index 0 is the first header byte) is XORed with a mask of (c[1:0]+1) ones in its low bits. All other bytes and the empty flag are unchanged.
- R9: In misinsertion mode (`mode` = 2), an event arms one pending insertion. The next empty slot leaves the block non-empty, with header `insHdr` and every payload byte equal to `insFill`. At most one insertion is pending at a time.
- R10: With `mode` = 3, no cell is impaired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Impairment enable; the table may be written while low |
| mode | input | 2 | 0 loss, 1 bit error, 2 misinsertion, 3 none |
| allCells | input | 1 | Treat every non-empty cell as matching |
| chanKey | input | 8*HDR_LEN | Header key |
| chanMask | input | 8*HDR_LEN | Header compare mask |
| insHdr | input | 8*HDR_LEN | Header of inserted cells |
| insFill | input | 8 | Payload byte of inserted cells |
| burstTab | input | 24 | Eight 3-bit burst codes |
| tabWe | input | 1 | Interval table write strobe |
| tabAddr | input | ADDR_W | Interval table write address |
| tabData | input | VAL_W | Interval table write value |
| inData | input | 8 | Input cell byte |
| inStart | input | 1 | Input first-byte strobe |
| inEmpty | input | 1 | Input empty-cell flag |
| outData | output | 8 | Output cell byte |
| outStart | output | 1 | Output first-byte strobe |
| outEmpty | output | 1 | Output empty-cell flag |

## Verification
The bench uses the default parameters:

- a 12-byte cell with a 4-byte header;
- a 64-entry table of 24-bit intervals;
- the error byte at index 5.

A short cell keeps every phase down to a few hundred cycles. With a 64-entry table, a full reload takes only 64 writes. Loading a constant table makes each event spacing exact, so loss, burst, error and insertion positions can be predicted cell by cell from the rules. The bench feeds a random mix of matching, non-matching and empty cells, plus directed phases for a zero entry, all-cells selection and the idle mode.

// File: rtl/cellimp_pkg.sv
package cellimp_pkg;
  typedef enum logic [1:0] {
    IMP_LOSS   = 2'd0,
    IMP_ERROR  = 2'd1,
    IMP_INSERT = 2'd2,
    IMP_NONE   = 2'd3
  } impMode_e;

  typedef struct packed {
    logic       drop;
    logic       corrupt;
    logic       insert;
    logic [7:0] errMask;
  } cellCmd_t;

  typedef struct packed {
    logic [7:0] d;
    logic       s;
    logic       e;
  } busByte_t;
endpackage

// File: rtl/cellimp_lfsr.sv
module cellimp_lfsr #(
  parameter int           W     = 17,
  parameter logic [W-1:0] TAPS  = 17'h12000,
  parameter logic [W-1:0] SEED  = 17'h00001,
  parameter int           OUT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             step,
  output logic [OUT_W-1:0] cur
);
  logic [W-1:0] st;
  logic         fb;

  assign fb  = ^(st & TAPS);
  assign cur = st[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)     st <= SEED;
    else if (step) st <= {st[W-2:0], fb};
  end

  always @(posedge clk) begin
    assert_lfsr_alive_R4: assert (!rstN || st != '0)
      else $error("shift register locked at zero");
  end
endmodule

// File: rtl/cellimp_ctrl.sv
module cellimp_ctrl
  import cellimp_pkg::*;
#(
  parameter int CELL_LEN = 12,
  parameter int HDR_LEN  = 4,
  parameter int ADDR_W   = 6,
  parameter int VAL_W    = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [1:0]           mode,
  input  logic                 allCells,
  input  logic [8*HDR_LEN-1:0] chanKey,
  input  logic [8*HDR_LEN-1:0] chanMask,
  input  logic [23:0]          burstTab,
  input  logic                 tabWe,
  input  logic [ADDR_W-1:0]    tabAddr,
  input  logic [VAL_W-1:0]     tabData,
  input  logic [7:0]           inData,
  input  logic                 inStart,
  input  logic                 inEmpty,
  output cellCmd_t             cmd
);
  localparam int HW    = 8 * HDR_LEN;
  localparam int LOW_W = HW - 8;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int IDX_W = $clog2(CELL_LEN + 1);

  impMode_e           impMode;
  logic [IDX_W-1:0]   idxReg, curIdx;
  logic               emptyReg, curEmpty;
  logic [LOW_W-1:0]   hdrLow;
  logic [HW-1:0]      hdrNow;
  logic               hdrDone, isMatch, active;
  logic [VAL_W-1:0]   tab [DEPTH];
  logic [VAL_W-1:0]   cnt, cntN, tabVal;
  logic [2:0]         burstLeft, burstN, burstCode, burstIdx;
  logic               insPend, pendN, eventStep;
  logic [ADDR_W-1:0]  addrCur;
  cellCmd_t           cmdN;
  logic [2:0]         errLen;

  assign impMode  = impMode_e'(mode);
  assign active   = enable && (impMode != IMP_NONE);
  assign curIdx   = inStart ? '0 : idxReg;
  assign curEmpty = inStart ? inEmpty : emptyReg;
  assign hdrNow   = {hdrLow, inData};
  assign hdrDone  = (curIdx == IDX_W'(HDR_LEN - 1));
  assign isMatch  = !curEmpty && (allCells || (((hdrNow ^ chanKey) & chanMask) == '0));
  assign tabVal   = (tab[addrCur] == '0) ? VAL_W'(1) : tab[addrCur];
  assign burstCode = burstTab[5'(burstIdx) * 5'd3 +: 3];
  assign errLen   = {1'b0, burstCode[1:0]} + 3'd1;

  cellimp_lfsr #(.W(17), .TAPS(17'h12000), .SEED(17'h0ACE1), .OUT_W(ADDR_W)) i_addrGen (
    .clk(clk), .rstN(rstN), .step(!active || eventStep), .cur(addrCur));

  cellimp_lfsr #(.W(17), .TAPS(17'h10004), .SEED(17'h1B00F), .OUT_W(3)) i_burstGen (
    .clk(clk), .rstN(rstN), .step(eventStep), .cur(burstIdx));

  always_ff @(posedge clk) begin
    if (tabWe && !enable) tab[tabAddr] <= tabData;
  end

  always_comb begin
    cntN      = cnt;
    burstN    = burstLeft;
    pendN     = insPend;
    cmdN      = cmd;
    eventStep = 1'b0;
    if (!active) begin
      cntN   = tabVal;
      burstN = '0;
      pendN  = 1'b0;
      if (hdrDone) cmdN = '0;
    end else if (hdrDone) begin
      cmdN = '0;
      if (curEmpty) begin
        if (impMode == IMP_INSERT && insPend) begin
          cmdN.insert = 1'b1;
          pendN       = 1'b0;
        end
      end else if (isMatch) begin
        if (burstLeft != '0) begin
          cmdN.drop = 1'b1;
          burstN    = burstLeft - 3'd1;
        end else if (cnt == VAL_W'(1)) begin
          eventStep = 1'b1;
          cntN      = tabVal;
          case (impMode)
            IMP_LOSS: begin
              cmdN.drop = 1'b1;
              burstN    = burstCode;
            end
            IMP_ERROR: begin
              cmdN.corrupt = 1'b1;
              cmdN.errMask = 8'((9'd1 << errLen) - 9'd1);
            end
            default: pendN = 1'b1;
          endcase
        end else begin
          cntN = cnt - VAL_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg    <= '0;
      emptyReg  <= 1'b1;
      hdrLow    <= '0;
      cnt       <= VAL_W'(1);
      burstLeft <= '0;
      insPend   <= 1'b0;
      cmd       <= '0;
    end else begin
      if (inStart) begin
        idxReg   <= IDX_W'(1);
        emptyReg <= inEmpty;
      end else if (idxReg != IDX_W'(CELL_LEN)) begin
        idxReg <= idxReg + IDX_W'(1);
      end
      if (curIdx < IDX_W'(HDR_LEN - 1)) hdrLow <= LOW_W'({hdrLow, inData});
      cnt       <= cntN;
      burstLeft <= burstN;
      insPend   <= pendN;
      cmd       <= cmdN;
    end
  end

  assert_one_action_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.drop, cmd.corrupt, cmd.insert}));
  assert_count_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> cnt != '0);
  assert_nomatch_clean_R3: assert property (@(posedge clk) disable iff (!rstN)
    hdrDone && !curEmpty && !isMatch |=> cmd == '0);
  assert_nomatch_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    hdrDone && active && !curEmpty && !isMatch |=> $stable(cnt));
  assert_burst_tail_R7: assert property (@(posedge clk) disable iff (!rstN)
    hdrDone && active && isMatch && burstLeft != '0 |=> cmd.drop);
endmodule

// File: rtl/cellimp_dp.sv
module cellimp_dp
  import cellimp_pkg::*;
#(
  parameter int CELL_LEN = 12,
  parameter int HDR_LEN  = 4,
  parameter int ERR_BYTE = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [8*HDR_LEN-1:0] insHdr,
  input  logic [7:0]           insFill,
  input  cellCmd_t             cmd,
  input  logic [7:0]           inData,
  input  logic                 inStart,
  input  logic                 inEmpty,
  output logic [7:0]           outData,
  output logic                 outStart,
  output logic                 outEmpty
);
  localparam int HW    = 8 * HDR_LEN;
  localparam int IDX_W = $clog2(CELL_LEN + 1);

  busByte_t         line [CELL_LEN];
  busByte_t         tail;
  cellCmd_t         actReg, curAct;
  logic [IDX_W-1:0] oIdxReg, curOIdx;
  logic [7:0]       insByte, nd;
  logic             ne, inCell;

  assign tail    = line[CELL_LEN-1];
  assign curOIdx = tail.s ? '0 : oIdxReg;
  assign curAct  = tail.s ? cmd : actReg;
  assign inCell  = curOIdx < IDX_W'(CELL_LEN);

  always_comb begin
    insByte = insFill;
    for (int b = 0; b < HDR_LEN; b++)
      if (curOIdx == IDX_W'(b)) insByte = insHdr[8*(HDR_LEN-1-b) +: 8];
  end

  always_comb begin
    nd = tail.d;
    ne = tail.e;
    if (inCell) begin
      if (curAct.drop) begin
        nd = '0;
        ne = 1'b1;
      end else if (curAct.insert) begin
        nd = insByte;
        ne = 1'b0;
      end else if (curAct.corrupt && curOIdx == IDX_W'(ERR_BYTE)) begin
        nd = tail.d ^ curAct.errMask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < CELL_LEN; k++) line[k] <= '{d: 8'd0, s: 1'b0, e: 1'b1};
      oIdxReg  <= IDX_W'(CELL_LEN);
      actReg   <= '0;
      outData  <= '0;
      outStart <= 1'b0;
      outEmpty <= 1'b1;
    end else begin
      line[0] <= '{d: inData, s: inStart, e: inEmpty};
      for (int k = 1; k < CELL_LEN; k++) line[k] <= line[k-1];
      if (tail.s) begin
        oIdxReg <= IDX_W'(1);
        actReg  <= cmd;
      end else if (oIdxReg != IDX_W'(CELL_LEN)) begin
        oIdxReg <= oIdxReg + IDX_W'(1);
      end
      outData  <= nd;
      outStart <= tail.s;
      outEmpty <= ne;
    end
  end

  assert_start_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    tail.s |=> outStart);
  assert_drop_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    tail.s && cmd.drop |=> outEmpty && outData == 8'd0);
  assert_insert_slot_R9: assert property (@(posedge clk) disable iff (!rstN)
    tail.s && cmd.insert |-> tail.e);
  assert_insert_header_R9: assert property (@(posedge clk) disable iff (!rstN)
    tail.s && cmd.insert |=> !outEmpty && outData == $past(insHdr[HW-8 +: 8]));
  assert_err_header_R8: assert property (@(posedge clk) disable iff (!rstN)
    tail.s && cmd.corrupt |=> outData == $past(tail.d) && outEmpty == $past(tail.e));
endmodule

// File: rtl/cell_impair_injector.sv
module cell_impair_injector
  import cellimp_pkg::*;
#(
  parameter int CELL_LEN = 12,
  parameter int HDR_LEN  = 4,
  parameter int ADDR_W   = 6,
  parameter int VAL_W    = 24,
  parameter int ERR_BYTE = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [1:0]           mode,
  input  logic                 allCells,
  input  logic [8*HDR_LEN-1:0] chanKey,
  input  logic [8*HDR_LEN-1:0] chanMask,
  input  logic [8*HDR_LEN-1:0] insHdr,
  input  logic [7:0]           insFill,
  input  logic [23:0]          burstTab,
  input  logic                 tabWe,
  input  logic [ADDR_W-1:0]    tabAddr,
  input  logic [VAL_W-1:0]     tabData,
  input  logic [7:0]           inData,
  input  logic                 inStart,
  input  logic                 inEmpty,
  output logic [7:0]           outData,
  output logic                 outStart,
  output logic                 outEmpty
);
  cellCmd_t cmd;

  cellimp_ctrl #(.CELL_LEN(CELL_LEN), .HDR_LEN(HDR_LEN), .ADDR_W(ADDR_W), .VAL_W(VAL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode), .allCells(allCells),
    .chanKey(chanKey), .chanMask(chanMask), .burstTab(burstTab),
    .tabWe(tabWe), .tabAddr(tabAddr), .tabData(tabData),
    .inData(inData), .inStart(inStart), .inEmpty(inEmpty), .cmd(cmd));

  cellimp_dp #(.CELL_LEN(CELL_LEN), .HDR_LEN(HDR_LEN), .ERR_BYTE(ERR_BYTE)) i_dp (
    .clk(clk), .rstN(rstN), .insHdr(insHdr), .insFill(insFill), .cmd(cmd),
    .inData(inData), .inStart(inStart), .inEmpty(inEmpty),
    .outData(outData), .outStart(outStart), .outEmpty(outEmpty));
endmodule

// File: tb/test_cell_impair_injector.sv
module test_cell_impair_injector;
  localparam int PERIOD = 10;
  localparam int L  = 12;
  localparam int H  = 4;
  localparam int AW = 6;
  localparam int VW = 24;
  localparam int EB = 5;
  localparam logic [31:0] KEY  = 32'h0012_3450;
  localparam logic [31:0] MASK = 32'h0FFF_FFF0;
  localparam logic [31:0] INS  = 32'hCAFE_0011;
  localparam logic [7:0]  FILL = 8'h6B;

  logic clk = 0, rstN = 0, enable = 0, allCells = 0, tabWe = 0;
  logic [1:0] mode = 0;
  logic [31:0] chanKey = KEY, chanMask = MASK, insHdr = INS;
  logic [7:0] insFill = FILL;
  logic [23:0] burstTab = 0;
  logic [AW-1:0] tabAddr = 0;
  logic [VW-1:0] tabData = 0;
  logic [7:0] inData = 0;
  logic inStart = 0, inEmpty = 1;
  logic [7:0] outData;
  logic outStart, outEmpty;

  int checks = 0, failures = 0;
  bit mEn = 0, mAll = 0, mPend = 0;
  int mMode = 0, mBurst = 0, mB = 0;
  logic [VW-1:0] mK = 0, mCnt = 1;
  logic [8*L:0] expQ[$];
  string tagQ[$];
  logic [8*L-1:0] capBuf;
  bit capEmp;
  int capN = 0;

  always #(PERIOD/2) clk = ~clk;

  cell_impair_injector #(.CELL_LEN(L), .HDR_LEN(H), .ADDR_W(AW), .VAL_W(VW), .ERR_BYTE(EB))
    i_cell_impair_injector (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode), .allCells(allCells),
    .chanKey(chanKey), .chanMask(chanMask), .insHdr(insHdr), .insFill(insFill),
    .burstTab(burstTab), .tabWe(tabWe), .tabAddr(tabAddr), .tabData(tabData),
    .inData(inData), .inStart(inStart), .inEmpty(inEmpty),
    .outData(outData), .outStart(outStart), .outEmpty(outEmpty));

  task automatic check(input bit ok, input string req, input logic [8*L:0] act, input logic [8*L:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] fixK(input logic [VW-1:0] k);
    return (k == 0) ? VW'(1) : k;
  endfunction

  // expected result per the requirements (R3..R10)
  function automatic void model(input logic [31:0] hdr, input bit emp, input logic [8*L-1:0] cin,
                                output logic [8*L-1:0] cout, output bit eout);
    bit match;
    cout = cin;
    eout = emp;
    if (!mEn || mMode == 3) return;
    match = !emp && (mAll || (((hdr ^ KEY) & MASK) == 0));
    if (emp) begin
      if (mMode == 2 && mPend) begin
        mPend = 0;
        eout = 0;
        cout = {INS, {(L-H){FILL}}};
      end
    end else if (match) begin
      if (mBurst > 0) begin
        mBurst--;
        cout = '0;
        eout = 1;
      end else if (mCnt == 1) begin
        mCnt = fixK(mK);
        if (mMode == 0) begin
          cout = '0;
          eout = 1;
          mBurst = mB;
        end else if (mMode == 1) begin
          cout[8*(L-1-EB) +: 8] = cin[8*(L-1-EB) +: 8] ^ 8'((9'd1 << (mB % 4 + 1)) - 9'd1);
        end else begin
          mPend = 1;
        end
      end else begin
        mCnt = mCnt - 1;
      end
    end
  endfunction

  task automatic sendCell(input int kind, input string tag);
    logic [31:0] hdr;
    logic [8*L-1:0] c, ec;
    bit ee, emp;
    hdr = (KEY & MASK) | ($urandom & ~MASK);
    if (kind == 1) hdr ^= 32'h10;
    emp = (kind == 2);
    for (int b = 0; b < L; b++) c[8*b +: 8] = 8'($urandom);
    c[8*L-1 -: 32] = hdr;
    model(hdr, emp, c, ec, ee);
    expQ.push_back({ee, ec});
    tagQ.push_back(tag);
    for (int b = 0; b < L; b++) begin
      inData = c[8*(L-1-b) +: 8];
      inStart = (b == 0);
      inEmpty = emp;
      @(negedge clk);
    end
    inStart = 0;
  endtask

  task automatic randCells(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int r;
      r = $urandom % 4;
      sendCell(r <= 1 ? 0 : (r == 2 ? 1 : 2), tag);
    end
  endtask

  task automatic configure(input int md, input logic [VW-1:0] k, input int code, input bit all, input bit en);
    enable = 0;
    @(negedge clk);
    for (int a = 0; a < (1 << AW); a++) begin
      tabWe = 1; tabAddr = AW'(a); tabData = k;
      @(negedge clk);
    end
    tabWe = 0;
    burstTab = {8{3'(code)}};
    mode = 2'(md);
    allCells = all;
    repeat (3) @(negedge clk);
    enable = en;
    mEn = en; mMode = md; mK = k; mB = code; mAll = all;
    mCnt = fixK(k); mBurst = 0; mPend = 0;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (outStart) begin
        capBuf = '0;
        capBuf[8*L-1 -: 8] = outData;
        capEmp = outEmpty;
        capN = 1;
      end else if (capN > 0 && capN < L) begin
        capBuf[8*(L-1-capN) +: 8] = outData;
        capN++;
      end
      if (capN == L) begin
        capN = 0;
        if (expQ.size() == 0) check(0, "R2 unexpected cell", {capEmp, capBuf}, '0);
        else begin
          logic [8*L:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check({capEmp, capBuf} === e, t, {capEmp, capBuf}, e);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250));
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(outStart == 0, "R1 start", {8'b0, outStart}, 0);
    check(outEmpty == 1, "R1 empty", {8'b0, outEmpty}, 1);
    check(outData == 0, "R1 data", {1'b0, outData}, 0);

    configure(0, 5, 0, 0, 0);   randCells(20, "R2 disabled");
    configure(0, 3, 0, 0, 1);   randCells(60, "R3 R4 R6 loss K=3");
    configure(0, 0, 0, 0, 1);   randCells(20, "R5 zero entry");
    configure(0, 4, 2, 0, 1);   randCells(60, "R7 burst of 3");
    configure(1, 2, 6, 0, 1);   randCells(30, "R8 error 3 bits");
    configure(1, 3, 3, 0, 1);   randCells(30, "R8 error 4 bits");
    configure(2, 2, 0, 0, 1);   randCells(60, "R9 insertion");
    configure(0, 3, 0, 1, 1);   randCells(40, "R3 all cells");
    configure(3, 1, 0, 0, 1);   randCells(20, "R10 mode none");
    for (int i = 0; i < 6; i++) sendCell(1, "R3 nonmatch directed");

    inStart = 0;
    repeat (3 * L + 4) @(negedge clk);
    check(expQ.size() == 0, "R2 all cells delivered", (8*L+1)'(expQ.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule